// File: doc/BRIEF.md
# Programmable-Size Address Window Decoder

This block keeps a 16-bit base-offset register on a small configuration bus and tells, in the same cycle, whether an incoming bus address falls inside the window that this offset describes. The window size is chosen at run time by a 4-bit size code N. The decoder compares only the N+1 most significant offset bits with the address lines they line up with. The offset bits below that field take no part in the match.

A mode input picks 24-bit or 32-bit addressing. The mode moves the offset onto a different slice of the address bus. In 24-bit mode the offset covers address lines 23..8. In 32-bit mode it covers lines 31..16.

Two resets come in. A hard reset clears the offset. A soft reset leaves the offset as it is and only holds off configuration writes while it is asserted.

Top module: `win_decoder`

## Requirements
- R1: When `hrst_n` is low at a rising clock edge, the offset register becomes 0x0000. This reset is synchronous and active-low, and it overrides any write in the same cycle.
- R2: When `srst_n` is low and `hrst_n` is high at a rising edge, the offset register keeps its value. A write presented in that cycle is dropped.
- R3: A write takes effect at the rising edge when `cfg_wr`=1 and `cfg_addr`=0x06. `cfg_be[1]`=1 loads bits 15..8 from `cfg_wdata[15:8]` and `cfg_be[0]`=1 loads bits 7..0 from `cfg_wdata[7:0]`. A lane whose enable is 0 keeps its value. A write to any other `cfg_addr` changes nothing.
- R4: `cfg_rdata` combinationally shows the offset register when `cfg_addr`=0x06 and shows 0x0000 for any other address.
- R5: With `mode_a32`=0 (24-bit mode), offset bit i is compared with `bus_addr[i+8]`. Address lines 31..24 and 7..0 never affect `hit`.
- R6: With `mode_a32`=1 (32-bit mode), offset bit i is compared with `bus_addr[i+16]`. Address lines 15..0 never affect `hit`.
- R7: For size code N (0..15), only offset bits 15 down to 15-N take part in the comparison, and the lower offset bits and their address lines are ignored. N=0 compares one bit and N=15 compares all sixteen.
- R8: `hit` is combinational. It is 1 only when `addr_valid`=1 and every compared bit matches, and it is 0 whenever `addr_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hrst_n | input | 1 | Hard reset, synchronous, active-low; clears the offset |
| srst_n | input | 1 | Soft reset, synchronous, active-low; keeps the offset and blocks writes |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration register address; the offset lives at 0x06 |
| cfg_be | input | 2 | Byte-lane enables: bit 1 for the upper byte, bit 0 for the lower byte |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Readback of the offset, or zero for other addresses |
| mode_a32 | input | 1 | 0 selects 24-bit address mode, 1 selects 32-bit mode |
| size_code | input | 4 | Window size code N; N+1 upper offset bits are compared |
| bus_addr | input | 32 | Incoming bus address |
| addr_valid | input | 1 | Qualifies `bus_addr` |
| hit | output | 1 | Address lies in the window |

## Verification
The bench builds the block with its default parameters: a 16-bit offset, a 32-bit address bus, the 8 and 16 alignment points and a 4-bit size code. With these values the whole space of size codes can be swept in both modes in a few hundred cycles. For each code and mode the bench checks an exact match, a flip of the lowest compared bit, a flip of the highest ignored bit, and a disturbance of the address lines outside the aligned slice. It also checks byte-lane writes and both resets against a behavioural model on every clock.

// File: rtl/win_dec_pkg.sv
// Package win_dec_pkg
// Shared types and constants for the address window decoder.
// Assumes: byte lanes are 8 bits wide.
package win_dec_pkg;
    localparam int LANE_W = 8;

    typedef enum logic {
        MODE_A24 = 1'b0,
        MODE_A32 = 1'b1
    } addr_mode_e;
endpackage

// File: rtl/win_ofs_reg.sv
// Module win_ofs_reg
// Holds the base offset, which is written one byte lane at a time.
// Hard reset clears the offset. Soft reset keeps it and blocks writes.
// Assumes: W is a multiple of the lane width, and both resets are synchronous and active-low.
module win_ofs_reg
    import win_dec_pkg::*;
#(
    parameter int W = 16,
    localparam int LANES = W / LANE_W
) (
    input  logic             clk,
    input  logic             hrst_n,
    input  logic             srst_n,
    input  logic             wr_en,
    input  logic [LANES-1:0] be,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     q
);
    // One register slice for each byte lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Purpose: clear on hard reset; load the lane when written outside soft reset.
        always_ff @(posedge clk) begin
            if (!hrst_n)
                q[g*LANE_W +: LANE_W] <= '0;
            else if (srst_n && wr_en && be[g])
                q[g*LANE_W +: LANE_W] <= wdata[g*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/win_mask_gen.sv
// Module win_mask_gen
// Turns the size code into a thermometer mask over the offset bits.
// A mask bit is set when its index is at least W-1-size.
// Assumes: 2**SIZE_W does not exceed W.
module win_mask_gen #(
    parameter int W      = 16,
    parameter int SIZE_W = 4
) (
    input  logic [SIZE_W-1:0] size,
    output logic [W-1:0]      mask
);
    // Purpose: enable the size+1 upper bits of the mask.
    always_comb begin
        for (int i = 0; i < W; i++)
            mask[i] = (i >= (W - 1 - int'(size)));
    end
endmodule

// File: rtl/win_addr_align.sv
// Module win_addr_align
// Takes from the address bus the W lines that the offset lines up with in the chosen mode.
// Assumes: LO_LSB + W and HI_LSB + W are no larger than ADDR_W.
module win_addr_align
    import win_dec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int W      = 16,
    parameter int LO_LSB = 8,
    parameter int HI_LSB = 16
) (
    input  addr_mode_e        mode,
    input  logic [ADDR_W-1:0] addr,
    output logic [W-1:0]      field
);
    logic [ADDR_W-1:0] shifted;

    // Purpose: shift the chosen slice down to bit 0 and keep W bits.
    always_comb begin
        shifted = (mode == MODE_A32) ? (addr >> HI_LSB) : (addr >> LO_LSB);
        field   = shifted[W-1:0];
    end
endmodule

// File: rtl/win_compare.sv
// Module win_compare
// Compares the masked address field with the masked offset and qualifies the result.
// Assumes: all inputs are stable within the cycle; the output is purely combinational.
module win_compare #(
    parameter int W = 16
) (
    input  logic [W-1:0] field,
    input  logic [W-1:0] ofs,
    input  logic [W-1:0] mask,
    input  logic         valid,
    output logic         hit
);
    // Purpose: report a hit when no enabled bit differs and the address is valid.
    always_comb begin
        hit = valid && (((field ^ ofs) & mask) == '0);
    end
endmodule

// File: rtl/win_decoder.sv
// Module win_decoder (top)
// Holds the base-offset register on the configuration bus and decodes bus addresses
// against it. The window size comes from a run-time size code.
// Assumes: one register address is decoded; any other address reads zero and cannot be written.
module win_decoder
    import win_dec_pkg::*;
#(
    parameter int              OFS_W    = 16,
    parameter int              ADDR_W   = 32,
    parameter int              CFG_AW   = 6,
    parameter logic [CFG_AW-1:0] REG_ADDR = 6'h06,
    parameter int              SIZE_W   = 4,
    parameter int              A24_LSB  = 8,
    parameter int              A32_LSB  = 16,
    localparam int             LANES    = OFS_W / LANE_W
) (
    input  logic              clk,
    input  logic              hrst_n,
    input  logic              srst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [LANES-1:0]  cfg_be,
    input  logic [OFS_W-1:0]  cfg_wdata,
    output logic [OFS_W-1:0]  cfg_rdata,
    input  logic              mode_a32,
    input  logic [SIZE_W-1:0] size_code,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              addr_valid,
    output logic              hit
);
    logic             reg_sel;
    logic             wr_en;
    logic [OFS_W-1:0] ofs_q;
    logic [OFS_W-1:0] cmp_mask;
    logic [OFS_W-1:0] addr_field;
    addr_mode_e       mode;

    // Purpose: decode the register address and the write strobe.
    always_comb begin
        reg_sel = (cfg_addr == REG_ADDR);
        wr_en   = cfg_wr && reg_sel;
        mode    = addr_mode_e'(mode_a32);
    end

    // Purpose: drive the readback mux.
    always_comb begin
        cfg_rdata = reg_sel ? ofs_q : '0;
    end

    win_ofs_reg #(.W(OFS_W)) u_reg (
        .clk    (clk),
        .hrst_n (hrst_n),
        .srst_n (srst_n),
        .wr_en  (wr_en),
        .be     (cfg_be),
        .wdata  (cfg_wdata),
        .q      (ofs_q)
    );

    win_mask_gen #(.W(OFS_W), .SIZE_W(SIZE_W)) u_mask (
        .size (size_code),
        .mask (cmp_mask)
    );

    win_addr_align #(
        .ADDR_W (ADDR_W),
        .W      (OFS_W),
        .LO_LSB (A24_LSB),
        .HI_LSB (A32_LSB)
    ) u_align (
        .mode  (mode),
        .addr  (bus_addr),
        .field (addr_field)
    );

    win_compare #(.W(OFS_W)) u_cmp (
        .field (addr_field),
        .ofs   (ofs_q),
        .mask  (cmp_mask),
        .valid (addr_valid),
        .hit   (hit)
    );
endmodule

// File: rtl/win_decoder_chk.sv
// Module win_decoder_chk
// Assertion checker attached to win_decoder through bind.
// Assumes: it is connected to the top-level ports and to the offset register output.
module win_decoder_chk #(
    parameter int OFS_W  = 16,
    parameter int ADDR_W = 32,
    parameter int CFG_AW = 6,
    parameter int SIZE_W = 4
) (
    input logic              clk,
    input logic              hrst_n,
    input logic              srst_n,
    input logic              cfg_wr,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [1:0]        cfg_be,
    input logic [OFS_W-1:0]  cfg_wdata,
    input logic [OFS_W-1:0]  ofs_q,
    input logic              mode_a32,
    input logic [SIZE_W-1:0] size_code,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              addr_valid,
    input logic              hit
);
    AST_HARD_CLEAR: assert property (@(posedge clk)
        !hrst_n |=> (ofs_q == '0)); // R1

    AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (!hrst_n)
        !srst_n |=> $stable(ofs_q)); // R2

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!hrst_n)
        !(cfg_wr && cfg_addr == 6'h06) |=> $stable(ofs_q)); // R3

    AST_LOW_LANE_ONLY: assert property (@(posedge clk) disable iff (!hrst_n)
        (srst_n && cfg_wr && cfg_addr == 6'h06 && cfg_be == 2'b01) |=>
        (ofs_q[15:8] == $past(ofs_q[15:8]) && ofs_q[7:0] == $past(cfg_wdata[7:0]))); // R3

    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!hrst_n)
        hit |-> addr_valid); // R8

    AST_FULL_A32_MATCH: assert property (@(posedge clk) disable iff (!hrst_n)
        (hit && mode_a32 && size_code == 4'hF) |-> (bus_addr[31:16] == ofs_q)); // R6

    AST_FULL_A24_MATCH: assert property (@(posedge clk) disable iff (!hrst_n)
        (hit && !mode_a32 && size_code == 4'hF) |-> (bus_addr[23:8] == ofs_q)); // R5

    AST_TOP_BIT_MATCH: assert property (@(posedge clk) disable iff (!hrst_n)
        (hit && mode_a32) |-> (bus_addr[31] == ofs_q[15])); // R7
endmodule

bind win_decoder win_decoder_chk #(
    .OFS_W  (OFS_W),
    .ADDR_W (ADDR_W),
    .CFG_AW (CFG_AW),
    .SIZE_W (SIZE_W)
) u_chk (
    .clk        (clk),
    .hrst_n     (hrst_n),
    .srst_n     (srst_n),
    .cfg_wr     (cfg_wr),
    .cfg_addr   (cfg_addr),
    .cfg_be     (cfg_be),
    .cfg_wdata  (cfg_wdata),
    .ofs_q      (ofs_q),
    .mode_a32   (mode_a32),
    .size_code  (size_code),
    .bus_addr   (bus_addr),
    .addr_valid (addr_valid),
    .hit        (hit)
);

// File: tb/win_decoder_test.sv
`timescale 1ns/1ps
module win_decoder_test;
    logic        clk = 1'b0;
    logic        hrst_n = 1'b0;
    logic        srst_n = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_addr = 6'h06;
    logic [1:0]  cfg_be = 2'b00;
    logic [15:0] cfg_wdata = 16'h0;
    logic [15:0] cfg_rdata;
    logic        mode_a32 = 1'b0;
    logic [3:0]  size_code = 4'h0;
    logic [31:0] bus_addr = 32'h0;
    logic        addr_valid = 1'b0;
    logic        hit;

    int errors = 0;
    int checks = 0;
    logic [15:0] m_ofs = 16'h0;

    always #4 clk = ~clk;

    win_decoder uut (
        .clk(clk), .hrst_n(hrst_n), .srst_n(srst_n), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .mode_a32(mode_a32), .size_code(size_code),
        .bus_addr(bus_addr), .addr_valid(addr_valid), .hit(hit)
    );

    // Reference window decision, computed bit by bit from the requirements.
    function automatic logic ref_hit(input logic [15:0] o, input logic [31:0] a,
                                     input logic m, input int n, input logic v);
        int lo = m ? 16 : 8;
        if (!v) return 1'b0;
        for (int k = 0; k <= n; k++)
            if (o[15-k] != a[lo+15-k]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: compare outputs with the model, then advance the model at the edge.
    task automatic tick(input string tag);
        #1;
        check("R4 readback", 32'(cfg_rdata), 32'((cfg_addr == 6'h06) ? m_ofs : 16'h0));
        check(tag, 32'(hit), 32'(ref_hit(m_ofs, bus_addr, mode_a32, int'(size_code), addr_valid)));
        @(posedge clk);
        if (!hrst_n) m_ofs = 16'h0;
        else if (srst_n && cfg_wr && cfg_addr == 6'h06) begin
            if (cfg_be[1]) m_ofs[15:8] = cfg_wdata[15:8];
            if (cfg_be[0]) m_ofs[7:0]  = cfg_wdata[7:0];
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] ad, input logic [1:0] be, input logic [15:0] d);
        cfg_wr = 1'b1; cfg_addr = ad; cfg_be = be; cfg_wdata = d;
        tick("R3 write cycle");
        cfg_wr = 1'b0; cfg_addr = 6'h06; cfg_be = 2'b00;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        tick("R1 in reset");
        hrst_n = 1'b1;
        tick("R1 after reset");
        check("R1 reset value", 32'(cfg_rdata), 32'h0);

        // R3: lane writes and stray addresses
        wr(6'h06, 2'b11, 16'h1234);
        #1 check("R3 full write", 32'(cfg_rdata), 32'h1234);
        wr(6'h06, 2'b10, 16'hAB00);
        #1 check("R3 upper lane", 32'(cfg_rdata), 32'hAB34);
        wr(6'h06, 2'b01, 16'h00CD);
        #1 check("R3 lower lane", 32'(cfg_rdata), 32'hABCD);
        wr(6'h04, 2'b11, 16'h5555);
        #1 check("R3 other address ignored", 32'(cfg_rdata), 32'hABCD);
        cfg_addr = 6'h07;
        #1 check("R4 other address reads zero", 32'(cfg_rdata), 32'h0);
        tick("R4 other addr");
        cfg_addr = 6'h06;

        // R2: soft reset keeps the value and drops a write
        srst_n = 1'b0;
        tick("R2 soft reset");
        wr(6'h06, 2'b11, 16'h0F0F);
        srst_n = 1'b1;
        #1 check("R2 soft reset keeps offset", 32'(cfg_rdata), 32'hABCD);

        // R8: valid low blocks a matching address
        size_code = 4'hF; mode_a32 = 1'b1; bus_addr = 32'hABCD_0000; addr_valid = 1'b0;
        #1 check("R8 no hit without valid", 32'(hit), 32'h0);
        tick("R8 invalid");
        addr_valid = 1'b1;
        #1 check("R8 hit with valid", 32'(hit), 32'h1);
        tick("R8 valid");

        // R5/R6/R7: every size code in both modes
        for (int m = 0; m < 2; m++) begin
            for (int n = 0; n < 16; n++) begin
                logic [15:0] o;
                logic [31:0] base;
                string mt;
                o = 16'hA5C3 ^ 16'(n * 16'h1111);
                mt = (m == 1) ? "R6" : "R5";
                wr(6'h06, 2'b11, o);
                mode_a32 = m[0]; size_code = n[3:0]; addr_valid = 1'b1;
                base = (m == 1) ? {o, 16'h9A7E} : {8'h6D, o, 8'h3C};
                bus_addr = base;
                #1 check({mt, " R7 exact match"}, 32'(hit), 32'h1);
                tick({mt, " exact"});
                bus_addr = base ^ (32'h1 << (((m == 1) ? 16 : 8) + 15 - n));
                #1 check({mt, " R7 lowest compared bit"}, 32'(hit), 32'h0);
                tick({mt, " R7 compared"});
                if (n < 15) begin
                    bus_addr = base ^ (32'h1 << (((m == 1) ? 16 : 8) + 14 - n));
                    #1 check({mt, " R7 highest ignored bit"}, 32'(hit), 32'h1);
                    tick({mt, " R7 ignored"});
                end
                bus_addr = (m == 1) ? (base ^ 32'h0000_FFFF) : (base ^ 32'hFF00_00FF);
                #1 check({mt, " outside lines ignored"}, 32'(hit), 32'h1);
                tick({mt, " outside"});
            end
        end

        // R1: hard reset clears after a nonzero value
        hrst_n = 1'b0;
        tick("R1 hard reset");
        hrst_n = 1'b1;
        #1 check("R1 hard reset clears", 32'(cfg_rdata), 32'h0);
        tick("R1 after");
        finish_run();
    end
endmodule